// File: doc/BRIEF.md
# Test Readout Sequence Generator

This block stands in for the outside timing system during self-test. A register write can launch one readout sequence or a free-running loop of them. Each sequence drives three control phases in turn: a fast-trigger gate, an early-trigger flag and a start strobe. An accept pulse may follow each sequence. A second command opens a sampling window on its own. The window is 4 cycles wide for the first four uses and grows by 4 cycles after every further four uses. A width-reset command returns it to 4 cycles. Inside the window a sample strobe fires on every cycle at the fast rate, or once per 4 cycles at the slow rate. A 7-bit level output either holds a written value or steps once every 4 cycles while sequences run. One base cycle stands for 200 ns / 4 (a 20 MHz base clock).

Nothing runs unless internal mode is selected twice: by a register bit and by the `mode_sw` input. Registers are written through a simple write strobe with address and data. Register map, with `wr_addr` and the fields of `wr_data`:
- 0 (mode): bit0 internal mode, bit1 fast sampling rate.
- 1 (sequence command): bit0 go, bit1 accept after each sequence, bit2 halt.
- 2: open a window (data ignored).
- 3: reset the window width (data ignored).
- 4 (level): bit7 ramp enable, bits 6:0 level.

The sequence state machine has the states SQ_IDLE, SQ_FASTOR, SQ_EFT, SQ_START and SQ_ACCEPT, and these transitions:
- SQ_IDLE to SQ_FASTOR on an accepted go.
- SQ_FASTOR to SQ_EFT, and SQ_EFT to SQ_START, when the phase ends.
- SQ_START to SQ_ACCEPT when accept was requested.
- Otherwise SQ_START, and likewise SQ_ACCEPT, goes to SQ_IDLE if a halt is pending and to SQ_FASTOR if not.
- Any state to SQ_IDLE when internal mode is lost.

The window state machine has the states WN_IDLE and WN_OPEN. It goes from WN_IDLE to WN_OPEN on an accepted open command, and back to WN_IDLE after the window length or when internal mode is lost.

Top module: `test_seq_gen`

## Requirements
- R1: After an accepted go, `fastor_o` is high for 8 cycles, then `eft_o` for 4 cycles, then `start_o` for 2 cycles. At most one of these outputs and `accept_o` is high at any time.
- R2: If bit1 is set in the go write, `accept_o` is high for exactly one cycle after each start phase; otherwise `accept_o` never rises.
- R3: Without the halt bit the sequence repeats with no gap. A halt written together with go gives exactly one sequence. A halt written later ends operation only after the current sequence, including its accept pulse, has completed.
- R4: Counting accepted open commands from reset or from the last width reset, the n-th window lasts 4·min(1+floor((n-1)/4), 15) cycles. The width saturates at 60 cycles.
- R5: A write to address 3 makes the next window 4 cycles wide again.
- R6: `samp_o` fires only while `win_o` is high. It fires every window cycle when bit1 of the mode register is 1. Otherwise it fires on the first of each group of 4 window cycles, which gives steps samples per window at the slow rate and 4·steps at the fast rate.
- R7: With bit7 of the level register set, `ramp_o` starts at the written level and rises by one, wrapping at 7 bits, after every 4 cycles in which `seq_busy_o` is high. With bit7 clear, `ramp_o` equals the written level.
- R8: Go, open and width-reset commands are ignored unless both the mode bit and `mode_sw` are 1. Losing either one drops every output of both state machines at once and returns them to idle.
- R9: A go written while a sequence runs is ignored. An open command written while a window is open is ignored and does not count as a use.
- R10: After reset all outputs are 0 and the first window is 4 cycles wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (one cycle = 50 ns of emulated time) |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sw | input | 1 | Internal-mode switch |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| fastor_o | output | 1 | Fast-trigger gate phase |
| eft_o | output | 1 | Early-trigger flag phase |
| start_o | output | 1 | Start strobe phase |
| accept_o | output | 1 | Accept pulse |
| seq_busy_o | output | 1 | Sequence running |
| win_o | output | 1 | Sampling window open |
| samp_o | output | 1 | Sample strobe |
| ramp_o | output | 7 | Ramp or static level |

## Verification
A wrong phase counter or a wrong next-state choice shows up within one sequence, 14 to 15 cycles, as a wrong number of high cycles on a phase output. It can also show as a missing or extra accept pulse, or as a wrong iteration count once a halt is written. A wrong width-step or use counter may stay hidden until the fifth open command. It then shows as a window length, and a sample count, different from the computed value, so the bench issues long runs of openings and resets with the step count modelled. A wrong prescaler for the level output shows as a wrong `ramp_o` right after a known number of busy cycles.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEQ   = 3'd1;
    localparam logic [ADDR_W-1:0] A_WOPEN = 3'd2;
    localparam logic [ADDR_W-1:0] A_WRST  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LEVEL = 3'd4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FASTOR,
        SQ_EFT,
        SQ_START,
        SQ_ACCEPT
    } seq_state_t;

    typedef enum logic {
        WN_IDLE,
        WN_OPEN
    } win_state_t;
endpackage

// File: rtl/tsg_regs.sv
module tsg_regs
    import tsg_pkg::*;
#(
    parameter int RAMP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sw,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              gen_active,
    output logic              fast_rate,
    output logic              go_cmd,
    output logic              accept_req,
    output logic              halt_cmd,
    output logic              win_start_cmd,
    output logic              win_reset_cmd,
    output logic              ramp_load,
    output logic              ramp_en,
    output logic [RAMP_W-1:0] ramp_level
);
    logic int_mode_q;
    logic fast_q;
    logic ramp_en_q;
    logic [RAMP_W-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_mode_q <= 1'b0;
            fast_q     <= 1'b0;
            ramp_en_q  <= 1'b0;
            level_q    <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MODE) begin
                int_mode_q <= wr_data[0];
                fast_q     <= wr_data[1];
            end
            if (wr_addr == A_LEVEL) begin
                ramp_en_q <= wr_data[DATA_W-1];
                level_q   <= wr_data[RAMP_W-1:0];
            end
        end
    end

    always_comb begin
        gen_active    = int_mode_q && mode_sw;
        fast_rate     = fast_q;
        go_cmd        = gen_active && wr_en && (wr_addr == A_SEQ) && wr_data[0];
        accept_req    = wr_data[1];
        halt_cmd      = gen_active && wr_en && (wr_addr == A_SEQ) && wr_data[2];
        win_start_cmd = gen_active && wr_en && (wr_addr == A_WOPEN);
        win_reset_cmd = gen_active && wr_en && (wr_addr == A_WRST);
        ramp_load     = wr_en && (wr_addr == A_LEVEL);
        ramp_en       = ramp_en_q;
        ramp_level    = level_q;
    end
endmodule

// File: rtl/tsg_seq_fsm.sv
module tsg_seq_fsm
    import tsg_pkg::*;
#(
    parameter int FASTOR_CYC = 8,
    parameter int EFT_CYC    = 4,
    parameter int START_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic go_cmd,
    input  logic accept_req,
    input  logic halt_cmd,
    output logic fastor_o,
    output logic eft_o,
    output logic start_o,
    output logic accept_o,
    output logic busy_o
);
    localparam int MAX_A = (FASTOR_CYC > EFT_CYC) ? FASTOR_CYC : EFT_CYC;
    localparam int MAX_PH = (MAX_A > START_CYC) ? MAX_A : START_CYC;
    localparam int CNT_W = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic acc_q;
    logic halt_q;
    logic phase_done;
    logic halt_now;

    always_comb begin
        unique case (state_q)
            SQ_FASTOR: phase_done = (cnt_q == CNT_W'(FASTOR_CYC - 1));
            SQ_EFT:    phase_done = (cnt_q == CNT_W'(EFT_CYC - 1));
            SQ_START:  phase_done = (cnt_q == CNT_W'(START_CYC - 1));
            default:   phase_done = 1'b1;
        endcase
    end

    assign halt_now = halt_q || halt_cmd;

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE:   if (go_cmd) state_d = SQ_FASTOR;
                SQ_FASTOR: if (phase_done) state_d = SQ_EFT;
                SQ_EFT:    if (phase_done) state_d = SQ_START;
                SQ_START: begin
                    if (phase_done) begin
                        if (acc_q)         state_d = SQ_ACCEPT;
                        else if (halt_now) state_d = SQ_IDLE;
                        else               state_d = SQ_FASTOR;
                    end
                end
                SQ_ACCEPT: state_d = halt_now ? SQ_IDLE : SQ_FASTOR;
                default:   state_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            acc_q   <= 1'b0;
            halt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
            if (state_q == SQ_IDLE && go_cmd) acc_q <= accept_req;
            if (state_d == SQ_IDLE) halt_q <= 1'b0;
            else if (halt_cmd)      halt_q <= 1'b1;
        end
    end

    always_comb begin
        fastor_o = 1'b0;
        eft_o    = 1'b0;
        start_o  = 1'b0;
        accept_o = 1'b0;
        busy_o   = active && (state_q != SQ_IDLE);
        unique case (state_q)
            SQ_FASTOR: fastor_o = active;
            SQ_EFT:    eft_o    = active;
            SQ_START:  start_o  = active;
            SQ_ACCEPT: accept_o = active;
            default:   ;
        endcase
    end
endmodule

// File: rtl/tsg_win_fsm.sv
module tsg_win_fsm
    import tsg_pkg::*;
#(
    parameter int STEP_CYC      = 4,
    parameter int USES_PER_STEP = 4,
    parameter int MAX_STEPS     = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic fast,
    input  logic start_cmd,
    input  logic reset_cmd,
    output logic win_o,
    output logic samp_o
);
    localparam int MAX_LEN = MAX_STEPS * STEP_CYC;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int STEP_W  = $clog2(MAX_STEPS + 1);
    localparam int USE_W   = (USES_PER_STEP > 1) ? $clog2(USES_PER_STEP) : 1;
    localparam int SUB_W   = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

    win_state_t state_q, state_d;
    logic [STEP_W-1:0] steps_q;
    logic [USE_W-1:0]  uses_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [SUB_W-1:0]  sub_q;
    logic              take;
    logic              last_cyc;

    assign take     = start_cmd && (state_q == WN_IDLE);
    assign last_cyc = (cnt_q == len_q - 1'b1);

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = WN_IDLE;
        end else begin
            unique case (state_q)
                WN_IDLE: if (take) state_d = WN_OPEN;
                WN_OPEN: if (last_cyc) state_d = WN_IDLE;
                default: state_d = WN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WN_IDLE;
            steps_q <= STEP_W'(1);
            uses_q  <= '0;
            len_q   <= LEN_W'(STEP_CYC);
            cnt_q   <= '0;
            sub_q   <= '0;
        end else begin
            state_q <= state_d;
            if (reset_cmd) begin
                steps_q <= STEP_W'(1);
                uses_q  <= '0;
            end else if (take) begin
                len_q <= LEN_W'(int'(steps_q) * STEP_CYC);
                if (uses_q == USE_W'(USES_PER_STEP - 1)) begin
                    uses_q <= '0;
                    if (steps_q != STEP_W'(MAX_STEPS)) steps_q <= steps_q + 1'b1;
                end else begin
                    uses_q <= uses_q + 1'b1;
                end
            end
            if (state_q == WN_OPEN) begin
                cnt_q <= cnt_q + 1'b1;
                sub_q <= (sub_q == SUB_W'(STEP_CYC - 1)) ? '0 : sub_q + 1'b1;
            end else begin
                cnt_q <= '0;
                sub_q <= '0;
            end
        end
    end

    always_comb begin
        win_o  = active && (state_q == WN_OPEN);
        samp_o = win_o && (fast || sub_q == '0);
    end
endmodule

// File: rtl/tsg_ramp.sv
module tsg_ramp #(
    parameter int RAMP_W   = 7,
    parameter int STEP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              en,
    input  logic [RAMP_W-1:0] level,
    input  logic [RAMP_W-1:0] load_val,
    input  logic              advance,
    output logic [RAMP_W-1:0] ramp_o
);
    localparam int PRE_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

    logic [RAMP_W-1:0] acc_q;
    logic [PRE_W-1:0]  pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            pre_q <= '0;
        end else if (load) begin
            acc_q <= load_val;
            pre_q <= '0;
        end else if (advance && en) begin
            if (pre_q == PRE_W'(STEP_CYC - 1)) begin
                pre_q <= '0;
                acc_q <= acc_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign ramp_o = en ? acc_q : level;
endmodule

// File: rtl/test_seq_gen.sv
module test_seq_gen
    import tsg_pkg::*;
#(
    parameter int FASTOR_CYC    = 8,
    parameter int EFT_CYC       = 4,
    parameter int START_CYC     = 2,
    parameter int STEP_CYC      = 4,
    parameter int USES_PER_STEP = 4,
    parameter int MAX_STEPS     = 15,
    parameter int RAMP_W        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sw,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic              fastor_o,
    output logic              eft_o,
    output logic              start_o,
    output logic              accept_o,
    output logic              seq_busy_o,
    output logic              win_o,
    output logic              samp_o,
    output logic [RAMP_W-1:0] ramp_o
);
    logic gen_active, fast_rate, go_cmd, accept_req, halt_cmd;
    logic win_start_cmd, win_reset_cmd, ramp_load, ramp_en;
    logic [RAMP_W-1:0] ramp_level;

    tsg_regs #(.RAMP_W(RAMP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode_sw(mode_sw),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gen_active(gen_active), .fast_rate(fast_rate),
        .go_cmd(go_cmd), .accept_req(accept_req), .halt_cmd(halt_cmd),
        .win_start_cmd(win_start_cmd), .win_reset_cmd(win_reset_cmd),
        .ramp_load(ramp_load), .ramp_en(ramp_en), .ramp_level(ramp_level)
    );

    tsg_seq_fsm #(
        .FASTOR_CYC(FASTOR_CYC), .EFT_CYC(EFT_CYC), .START_CYC(START_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .active(gen_active),
        .go_cmd(go_cmd), .accept_req(accept_req), .halt_cmd(halt_cmd),
        .fastor_o(fastor_o), .eft_o(eft_o), .start_o(start_o),
        .accept_o(accept_o), .busy_o(seq_busy_o)
    );

    tsg_win_fsm #(
        .STEP_CYC(STEP_CYC), .USES_PER_STEP(USES_PER_STEP), .MAX_STEPS(MAX_STEPS)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .active(gen_active), .fast(fast_rate),
        .start_cmd(win_start_cmd), .reset_cmd(win_reset_cmd),
        .win_o(win_o), .samp_o(samp_o)
    );

    tsg_ramp #(.RAMP_W(RAMP_W), .STEP_CYC(STEP_CYC)) u_ramp (
        .clk(clk), .rst_n(rst_n), .load(ramp_load), .en(ramp_en),
        .level(ramp_level), .load_val(wr_data[RAMP_W-1:0]),
        .advance(seq_busy_o), .ramp_o(ramp_o)
    );
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker #(
    parameter int STEP_CYC  = 4,
    parameter int MAX_STEPS = 15,
    parameter int RAMP_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              gen_active,
    input logic              fastor_o,
    input logic              eft_o,
    input logic              start_o,
    input logic              accept_o,
    input logic              seq_busy_o,
    input logic              win_o,
    input logic              samp_o,
    input logic [RAMP_W-1:0] ramp_o
);
    localparam int MAX_LEN = MAX_STEPS * STEP_CYC;
    localparam int RUN_W   = $clog2(MAX_LEN + 2);

    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               run_q <= '0;
        else if (win_o && run_q != RUN_W'(MAX_LEN + 1)) run_q <= run_q + 1'b1;
        else if (!win_o)                          run_q <= '0;
    end

    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fastor_o, eft_o, start_o, accept_o}));

    assert_accept_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o);

    assert_end_after_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(seq_busy_o) && gen_active) |-> $past(start_o || accept_o));

    assert_loop_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fastor_o) && $past(seq_busy_o)) |-> $past(start_o || accept_o));

    assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_o |-> (run_q < RUN_W'(MAX_LEN)));

    assert_samp_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        samp_o |-> win_o);

    assert_ramp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy_o && !wr_en) |=> $stable(ramp_o));

    assert_inactive_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_active |-> (!seq_busy_o && !win_o));
endmodule

bind test_seq_gen tsg_checker #(
    .STEP_CYC(STEP_CYC), .MAX_STEPS(MAX_STEPS), .RAMP_W(RAMP_W)
) u_tsg_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .gen_active(gen_active),
    .fastor_o(fastor_o), .eft_o(eft_o), .start_o(start_o),
    .accept_o(accept_o), .seq_busy_o(seq_busy_o), .win_o(win_o),
    .samp_o(samp_o), .ramp_o(ramp_o)
);

// File: tb/test_seq_gen_bench.sv
module test_seq_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sw = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic fastor_o, eft_o, start_o, accept_o, seq_busy_o, win_o, samp_o;
    logic [6:0] ramp_o;

    int checks = 0;
    int errors = 0;
    int m_steps = 1;
    int m_uses = 0;
    bit done = 0;

    test_seq_gen u_test_seq_gen (
        .clk(clk), .rst_n(rst_n), .mode_sw(mode_sw),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fastor_o(fastor_o), .eft_o(eft_o), .start_o(start_o),
        .accept_o(accept_o), .seq_busy_o(seq_busy_o), .win_o(win_o),
        .samp_o(samp_o), .ramp_o(ramp_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int exp_len(input int steps);
        return 4 * steps;
    endfunction

    function automatic int exp_samps(input int steps, input bit fast);
        return fast ? 4 * steps : steps;
    endfunction

    // model advance for an accepted open command (R4)
    task automatic model_take();
        m_uses++;
        if (m_uses == 4) begin
            m_uses = 0;
            if (m_steps < 15) m_steps++;
        end
    endtask

    // opens a window and measures it; optional ignored re-open inside (R9)
    task automatic do_window(input bit fast, input bit poke, input string req);
        int len = 0;
        int smp = 0;
        int steps_now = m_steps;
        wr(3'd0, {6'd0, fast, 1'b1});
        wr(3'd2, 8'h00);
        model_take();
        while (win_o && len < 200) begin
            len++;
            if (samp_o) smp++;
            if (poke && len == 1) begin
                wr_en = 1'b1; wr_addr = 3'd2;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(req, len, exp_len(steps_now));
        check("R6 samples", smp, exp_samps(steps_now, fast));
    endtask

    // runs a sequence; halt_it>0 writes go|halt during that iteration
    task automatic run_seq(input logic [7:0] d, input int halt_it, input string req);
        int it = 0, fo = 0, ef = 0, st = 0, ac = 0, guard = 0;
        bit prev_fo = 0, sent = 0;
        int exp_it = (halt_it == 0) ? 1 : halt_it;
        wr(3'd1, d);
        while (seq_busy_o && guard < 2000) begin
            guard++;
            if (fastor_o && !prev_fo) it++;
            prev_fo = fastor_o;
            if (fastor_o) fo++;
            if (eft_o) ef++;
            if (start_o) st++;
            if (accept_o) ac++;
            if (halt_it != 0 && it == halt_it && !sent) begin
                sent = 1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h05;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        check({req, " iterations"}, it, exp_it);
        check("R1 fastor cycles", fo, 8 * exp_it);
        check("R1 eft cycles", ef, 4 * exp_it);
        check("R1 start cycles", st, 2 * exp_it);
        check("R2 accept cycles", ac, d[1] ? exp_it : 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 busy", seq_busy_o, 0);
        check("R10 win", win_o, 0);
        check("R10 ramp", ramp_o, 0);
        check("R10 phases", {fastor_o, eft_o, start_o, accept_o, samp_o}, 0);
        rst_n = 1'b1;
        mode_sw = 1'b1;
        wr(3'd0, 8'h01);

        do_window(1'b0, 1'b0, "R10 first width");

        // random mix of openings and width resets (R4, R5, R6, R9)
        for (int i = 0; i < 40; i++) begin
            int r = $urandom_range(0, 9);
            if (r == 0) begin
                wr(3'd3, 8'h00);
                m_steps = 1; m_uses = 0;
                do_window($urandom_range(0, 1) == 1, 1'b0, "R5 after reset");
            end else begin
                do_window($urandom_range(0, 1) == 1, r < 3, r < 3 ? "R9 reopen ignored" : "R4 width");
            end
        end
        // saturation (R4)
        wr(3'd3, 8'h00);
        m_steps = 1; m_uses = 0;
        for (int i = 0; i < 66; i++) do_window(i[0], 1'b0, "R4 saturate");
        check("R4 model saturated", m_steps, 15);
        wr(3'd3, 8'h00);
        m_steps = 1; m_uses = 0;
        do_window(1'b1, 1'b0, "R5 reset width");

        // sequences (R1, R2, R3, R9)
        run_seq(8'h05, 0, "R3 single");
        run_seq(8'h07, 0, "R2 single accept");
        run_seq(8'h01, 3, "R3 loop halt");
        run_seq(8'h03, 2, "R3 loop accept halt");
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d = {5'd0, 1'b0, 1'($urandom_range(0, 1)), 1'b1};
            run_seq(d, $urandom_range(1, 4), "R3 random loop");
        end

        // ramp (R7)
        wr(3'd4, 8'h85);
        check("R7 load", ramp_o, 5);
        run_seq(8'h05, 0, "R7 seq");
        check("R7 ramp after 14 busy", ramp_o, 8);
        wr(3'd4, 8'hFE);
        run_seq(8'h05, 0, "R7 seq");
        check("R7 ramp wrap", ramp_o, 1);
        wr(3'd4, 8'h25);
        run_seq(8'h05, 0, "R7 seq");
        check("R7 static", ramp_o, 8'h25);

        // mode gating (R8)
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        check("R8 go ignored reg off", seq_busy_o, 0);
        wr(3'd2, 8'h00);
        check("R8 open ignored reg off", win_o, 0);
        wr(3'd0, 8'h01);
        mode_sw = 1'b0;
        wr(3'd1, 8'h01);
        check("R8 go ignored sw off", seq_busy_o, 0);
        mode_sw = 1'b1;
        @(negedge clk);
        check("R8 stays idle", seq_busy_o, 0);
        wr(3'd1, 8'h01);
        repeat (5) @(negedge clk);
        check("R8 loop running", seq_busy_o, 1);
        mode_sw = 1'b0;
        #1;
        check("R8 abort immediate", {seq_busy_o, fastor_o, eft_o, start_o}, 0);
        @(negedge clk);
        mode_sw = 1'b1;
        @(negedge clk);
        check("R8 idle after abort", seq_busy_o, 0);
        do_window(1'b0, 1'b0, "R8 width unaffected");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule